// File: doc/BRIEF.md
# Fly-by DMA Peripheral Port

This block is the device-side end of a fly-by DMA path for an endpoint-style peripheral. The core side loads received bytes into a receive buffer and marks the end of each packet. Once a complete packet is waiting, the block raises a transfer request towards an external DMA controller. The controller confirms the transfer with an acknowledge. It then pulls bytes with an active-low read strobe or pushes bytes with an active-low write strobe. Bytes pushed by the controller go into a transmit buffer, which the core side drains through a simple pop port.

A configuration input chooses the handshake. With the input at 0 this handshake is in force. With it at 1 the block stays silent on the DMA side: the request is held low, the strobes are ignored and the bus is never driven. The external data bus is split into an input, an output and an output enable, so that a pad ring or tri-state buffer can be placed outside the block. The strobes are sampled on `clk` and must be synchronous to it.

Top module: `dma_flyby_port`

## Requirements
- R1: While `cfg_alt_mode` is 1, `xfer_req` is 0, `bus_oe` is 0, and the read and write strobes change neither buffer.
- R2: With `cfg_alt_mode` at 0, `xfer_req` is 1 exactly when at least one byte covered by a `core_pkt_end` is still unread. Bytes that are written but not yet followed by `core_pkt_end` do not raise it. It drops in the cycle after the last such byte is consumed.
- R3: `bus_oe` is 1 only while the mode is 0, `xfer_ack` is 1 and `rd_stb_n` is 0. During that time `bus_o` shows the oldest unread receive byte.
- R4: A receive byte is consumed on a 0-to-1 transition of `rd_stb_n` seen at a clock edge while `xfer_ack` is 1. A read strobe without acknowledge consumes nothing.
- R5: On a 0-to-1 transition of `wr_stb_n` seen while `xfer_ack` is 1, the value on `bus_i` is stored in the transmit buffer. The core side sees stored bytes on `core_rd_data` in arrival order, with `core_rd_valid` high while any are held; `core_rd_en` removes the oldest.
- R6: A write strobe without acknowledge stores nothing.
- R7: A byte offered to a full buffer is dropped. This applies to core writes into the receive buffer and to strobed writes into the transmit buffer. The bytes already held are kept intact.
- R8: After reset, `xfer_req`, `bus_oe` and `core_rd_valid` are 0.
- R9: After the receive data has been drained, `xfer_req` rises again only when a new `core_pkt_end` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_alt_mode | input | 1 | 0 selects this handshake, 1 disables it |
| core_wr_en | input | 1 | Core writes a byte into the receive buffer |
| core_wr_data | input | DW | Byte written by the core |
| core_pkt_end | input | 1 | Marks all bytes written so far (this cycle included) as a packet |
| core_rd_en | input | 1 | Core pops the oldest transmit byte |
| core_rd_data | output | DW | Oldest transmit byte |
| core_rd_valid | output | 1 | Transmit buffer holds data |
| xfer_req | output | 1 | Transfer request to the DMA controller |
| xfer_ack | input | 1 | Acknowledge from the DMA controller, active high |
| rd_stb_n | input | 1 | Active-low strobe: block drives a byte |
| wr_stb_n | input | 1 | Active-low strobe: block captures a byte |
| bus_i | input | DW | Data bus input |
| bus_o | output | DW | Data bus output |
| bus_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with a buffer depth of 4 and an 8-bit data width. The small depth lets both full conditions be reached with only a few strobes. A six-byte packet overflows the receive side and five strobed writes overflow the transmit side. This also makes the pointers wrap several times within the short directed scenarios.

// File: rtl/dma_flyby_port.sv
module dma_flyby_port #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_alt_mode,
  input  logic          core_wr_en,
  input  logic [DW-1:0] core_wr_data,
  input  logic          core_pkt_end,
  input  logic          core_rd_en,
  output logic [DW-1:0] core_rd_data,
  output logic          core_rd_valid,
  output logic          xfer_req,
  input  logic          xfer_ack,
  input  logic          rd_stb_n,
  input  logic          wr_stb_n,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic active;
  logic rd_q, wr_q;
  logic rd_rise, wr_rise;

  assign active  = !cfg_alt_mode;
  assign rd_rise = active && xfer_ack && rd_stb_n && !rd_q;
  assign wr_rise = active && xfer_ack && wr_stb_n && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_stb_n;
      wr_q <= wr_stb_n;
    end
  end

  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt, rx_avail, rx_cnt_nx;
  logic          rx_push, rx_pop;

  assign rx_push   = core_wr_en && (rx_cnt != FULL);
  assign rx_pop    = rd_rise && (rx_avail != '0);
  assign rx_cnt_nx = rx_cnt + CW'(rx_push) - CW'(rx_pop);

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= core_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_cnt   <= '0;
      rx_avail <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt   <= rx_cnt_nx;
      rx_avail <= core_pkt_end ? rx_cnt_nx : rx_avail - CW'(rx_pop);
    end
  end

  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_push, tx_pop;

  assign tx_push = wr_rise && (tx_cnt != FULL);
  assign tx_pop  = core_rd_en && (tx_cnt != '0);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  assign xfer_req      = active && (rx_avail != '0);
  assign bus_oe        = active && xfer_ack && !rd_stb_n;
  assign bus_o         = rx_mem[rx_rp];
  assign core_rd_data  = tx_mem[tx_rp];
  assign core_rd_valid = (tx_cnt != '0);
endmodule

// File: rtl/dma_flyby_port_chk.sv
module dma_flyby_port_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_alt_mode,
  input logic          xfer_ack,
  input logic          xfer_req,
  input logic          bus_oe,
  input logic [DW-1:0] bus_o,
  input logic [AW-1:0] rx_rp,
  input logic [AW-1:0] tx_wp,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] rx_avail,
  input logic [CW-1:0] tx_cnt
);
  assert_rdptr_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ack || cfg_alt_mode) |=> $stable(rx_rp));

  assert_wrptr_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ack || cfg_alt_mode) |=> $stable(tx_wp));

  assert_req_drops_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_alt_mode && !$past(cfg_alt_mode) && $fell(xfer_req)) |-> ($past(rx_avail) == CW'(1)));

  assert_bus_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && $past(rx_cnt) != '0) |-> $stable(bus_o));

  assert_rx_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (rx_avail <= rx_cnt));

  assert_tx_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  assert_mode_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_alt_mode |-> (!xfer_req && !bus_oe));
endmodule

bind dma_flyby_port dma_flyby_port_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_alt_mode(cfg_alt_mode), .xfer_ack(xfer_ack),
  .xfer_req(xfer_req), .bus_oe(bus_oe), .bus_o(bus_o), .rx_rp(rx_rp), .tx_wp(tx_wp),
  .rx_cnt(rx_cnt), .rx_avail(rx_avail), .tx_cnt(tx_cnt)
);

// File: tb/dma_flyby_port_bench.sv
module dma_flyby_port_bench;
  localparam int DEPTH = 4;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_alt_mode = 1'b0;
  logic core_wr_en = 1'b0, core_pkt_end = 1'b0, core_rd_en = 1'b0;
  logic [DW-1:0] core_wr_data = '0, bus_i = '0;
  logic xfer_ack = 1'b0, rd_stb_n = 1'b1, wr_stb_n = 1'b1;
  logic [DW-1:0] core_rd_data, bus_o;
  logic core_rd_valid, xfer_req, bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_flyby_port #(.DEPTH(DEPTH), .DW(DW)) u_dma_flyby_port (
    .clk(clk), .rst_n(rst_n), .cfg_alt_mode(cfg_alt_mode),
    .core_wr_en(core_wr_en), .core_wr_data(core_wr_data), .core_pkt_end(core_pkt_end),
    .core_rd_en(core_rd_en), .core_rd_data(core_rd_data), .core_rd_valid(core_rd_valid),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(int n, logic [7:0] base, bit commit);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core_wr_en   = 1'b1;
      core_wr_data = base + 8'(i);
      core_pkt_end = commit && (i == n - 1);
    end
    @(negedge clk);
    core_wr_en   = 1'b0;
    core_pkt_end = 1'b0;
  endtask

  task automatic commit_only();
    @(negedge clk);
    core_pkt_end = 1'b1;
    @(negedge clk);
    core_pkt_end = 1'b0;
  endtask

  task automatic dma_read(logic [7:0] exp, string tag);
    @(negedge clk);
    xfer_ack = 1'b1;
    rd_stb_n = 1'b0;
    @(negedge clk);
    check({tag, " oe during read"}, 32'(bus_oe), 32'(!cfg_alt_mode));
    if (!cfg_alt_mode) check({tag, " read byte"}, 32'(bus_o), 32'(exp));
    rd_stb_n = 1'b1;
    @(negedge clk);
    check({tag, " oe after read"}, 32'(bus_oe), 0);
    xfer_ack = 1'b0;
  endtask

  task automatic dma_write(logic [7:0] val, bit ack);
    @(negedge clk);
    xfer_ack = ack;
    wr_stb_n = 1'b0;
    bus_i    = val;
    @(negedge clk);
    wr_stb_n = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  task automatic core_pop(logic [7:0] exp, string tag);
    @(negedge clk);
    check({tag, " valid"}, 32'(core_rd_valid), 1);
    check({tag, " data"}, 32'(core_rd_data), 32'(exp));
    core_rd_en = 1'b1;
    @(negedge clk);
    core_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 req after reset", 32'(xfer_req), 0);
    check("R8 oe after reset", 32'(bus_oe), 0);
    check("R8 valid after reset", 32'(core_rd_valid), 0);
  endtask

  task automatic t_packet();
    push(2, 8'h10, 1'b0);
    @(negedge clk);
    check("R2 uncommitted no req", 32'(xfer_req), 0);
    commit_only();
    check("R2 req after commit", 32'(xfer_req), 1);
    dma_read(8'h10, "R3 b0");
    check("R2 req mid packet", 32'(xfer_req), 1);
    dma_read(8'h11, "R3 b1");
    check("R2 req after last byte", 32'(xfer_req), 0);
    repeat (3) @(negedge clk);
    check("R9 req stays low", 32'(xfer_req), 0);
    push(1, 8'h20, 1'b1);
    @(negedge clk);
    check("R9 req on new packet", 32'(xfer_req), 1);
  endtask

  task automatic t_noack_read();
    @(negedge clk);
    rd_stb_n = 1'b0;
    @(negedge clk);
    check("R3 no oe without ack", 32'(bus_oe), 0);
    rd_stb_n = 1'b1;
    @(negedge clk);
    check("R4 req kept without ack", 32'(xfer_req), 1);
    dma_read(8'h20, "R4 byte kept");
    check("R4 drained", 32'(xfer_req), 0);
  endtask

  task automatic t_mode_rx();
    push(1, 8'h30, 1'b1);
    @(negedge clk);
    cfg_alt_mode = 1'b1;
    @(negedge clk);
    check("R1 req low in alt mode", 32'(xfer_req), 0);
    dma_read(8'h30, "R1 alt read");
    cfg_alt_mode = 1'b0;
    @(negedge clk);
    check("R1 req back", 32'(xfer_req), 1);
    dma_read(8'h30, "R1 byte kept");
  endtask

  task automatic t_write();
    dma_write(8'hA1, 1'b1);
    dma_write(8'hA2, 1'b1);
    dma_write(8'hEE, 1'b0);
    cfg_alt_mode = 1'b1;
    dma_write(8'hEF, 1'b1);
    cfg_alt_mode = 1'b0;
    core_pop(8'hA1, "R5 first");
    core_pop(8'hA2, "R5 second");
    @(negedge clk);
    check("R6 no-ack and alt-mode writes dropped", 32'(core_rd_valid), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH + 1; i++) dma_write(8'h50 + 8'(i), 1'b1);
    for (int i = 0; i < DEPTH; i++) core_pop(8'h50 + 8'(i), "R7 tx kept");
    @(negedge clk);
    check("R7 tx extra dropped", 32'(core_rd_valid), 0);
    push(DEPTH + 2, 8'h40, 1'b1);
    for (int i = 0; i < DEPTH; i++) dma_read(8'h40 + 8'(i), "R7 rx kept");
    check("R7 rx extra dropped", 32'(xfer_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_packet();
    t_noack_read();
    t_mode_rx();
    t_write();
    t_overflow();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule